// File: doc/BRIEF.md
# Pipelined Burst Memory Cycle Controller

This block is the synchronous front end of an on-chip memory with burst access. On every rising clock edge it samples a set of active-low control strobes and classifies the cycle as one of four kinds: deselect, begin-burst, continue-burst or suspend-burst. There are two ways to load a fresh address. The processor load strobe only counts while the chip enable is low. The controller load strobe counts on its own.

Writes go into an internal array, one 9-bit lane at a time: eight data bits plus one parity bit per lane. A read returns its word through a one-cycle output register. The data bus is split into a write-data input, a read-data output and a drive flag, so there are no tristate pins.

Inside a burst, the low two address bits of a continued access come from a separate burst-order sequencer through a dedicated input. A nap input freezes all clocked state and the array contents. The first cycle after a nap always acts as a deselect.

Top module: `sram_burst_ctl`

## Requirements
- R1: When a load is requested (`ld_ctl_n` low, or `ld_cpu_n` and `en_n` both low) but the chip is not selected, the cycle is a deselect. The chip is selected only when `en_n` is low, `sel_hi` is high and `sel_lo_n` is low. A deselect performs no write, starts no read, and ends any burst, so later cycles without a load access nothing.
- R2: `ld_cpu_n` low has no effect while `en_n` is high. If `ld_ctl_n` is also high, such a cycle continues or suspends the current burst exactly as if both load strobes were high.
- R3: In a cycle started by `ld_cpu_n` (with `en_n` low), `wr_all_n`, `lane_en_n` and `lane_sel_n` are ignored and the cycle is a read. The array is left unchanged.
- R4: A selected cycle started only by `ld_ctl_n` loads `addr_i` and applies the write controls of that same cycle.
- R5: With both load strobes inactive, `step_n` low and a burst open, the access address becomes the loaded upper bits joined with `seq_lo_i` as its two low bits.
- R6: With both load strobes inactive, `step_n` high and a burst open, the current address is accessed again.
- R7: `wr_all_n` low writes every lane whatever `lane_sel_n` is. Otherwise, `lane_en_n` low writes each lane whose `lane_sel_n` bit is low. `lane_en_n` high blocks the lane selects and the cycle is a read.
- R8: Lane k covers `wdata_i[8k+7:8k]` together with parity bit `wdata_i[32+k]`. Any combination of lanes can be written in one cycle, and unselected lanes keep their contents.
- R9: The word of a read accepted on clock edge E appears on `rdata_o`, with `drive_o` high, right after edge E+1. Each further burst access adds one word per edge.
- R10: `drive_o` is low whenever `out_en_n` is high, `nap_i` is high, or the write controls request a write (`wr_all_n` low, or `lane_en_n` low with any `lane_sel_n` bit low) in a cycle that is not started by `ld_cpu_n`.
- R11: While `nap_i` is high, the address, burst state, output register and array all hold. The first edge after `nap_i` falls is treated as a deselect, whatever the strobes are.
- R12: A word written on one edge is returned by a read of the same address accepted on the next edge.
- R13: While `rst_n` is low, and after it rises, `drive_o` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Chip enable, active low; also gates the processor load strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| ld_cpu_n | input | 1 | Processor address-load strobe, active low |
| ld_ctl_n | input | 1 | Controller address-load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_en_n | input | 1 | Lane-select enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| nap_i | input | 1 | Freeze request, active high |
| addr_i | input | log2(DEPTH) | Word address for a load |
| seq_lo_i | input | 2 | Next low address bits from the burst-order sequencer |
| wdata_i | input | LANES*9 | Write data, parity bits on top |
| rdata_o | output | LANES*9 | Registered read data |
| drive_o | output | 1 | High when the read data is to be driven |

## Verification
The most delicate overlap is a pipelined read word leaving the output register in the same cycle that the next cycle requests a write. The word must then stay in `rdata_o` while `drive_o` drops. A cycle started by the processor strobe that also carries active write controls is the mirror case: there the drive must stay up and the array untouched. Both are forced by directed sequences (a suspend cycle with lane selects right after a read, and a processor start with `wr_all_n` low). Random traffic also mixes them freely. Every cycle, a bench model that holds its own copy of the array and the two pipeline stages judges `drive_o` and `rdata_o`.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Kind of cycle decided at a clock edge
    typedef enum logic [2:0] {
        CY_IDLE  = 3'd0,  // nothing open, nothing loaded
        CY_DESEL = 3'd1,  // load while unselected, or wake-up cycle
        CY_BEGIN = 3'd2,  // fresh address loaded
        CY_CONT  = 3'd3,  // burst moves to next sequenced address
        CY_SUSP  = 3'd4   // burst repeats current address
    } cyc_e;

endpackage

// File: rtl/sbc_cycle_dec.sv
module sbc_cycle_dec (
    input  logic          en_n,
    input  logic          sel_hi,
    input  logic          sel_lo_n,
    input  logic          ld_cpu_n,
    input  logic          ld_ctl_n,
    input  logic          step_n,
    input  logic          nap,
    input  logic          woke,
    input  logic          act_q,
    output sbc_pkg::cyc_e cyc,
    output logic          cpu_go,
    output logic          wr_ok
);
    import sbc_pkg::*;

    logic chip_on;
    logic load;

    always_comb begin
        chip_on = ~en_n & sel_hi & ~sel_lo_n;
        cpu_go  = ~ld_cpu_n & ~en_n;
        load    = cpu_go | ~ld_ctl_n;

        if (nap) begin
            cyc = CY_IDLE;
        end else if (woke) begin
            cyc = CY_DESEL;
        end else if (load) begin
            cyc = chip_on ? CY_BEGIN : CY_DESEL;
        end else if (act_q) begin
            cyc = step_n ? CY_SUSP : CY_CONT;
        end else begin
            cyc = CY_IDLE;
        end

        // a processor-started cycle is always a read
        wr_ok = ((cyc == CY_BEGIN) & ~cpu_go) | (cyc == CY_CONT) | (cyc == CY_SUSP);
    end

endmodule

// File: rtl/sbc_lane_dec.sv
module sbc_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             wr_all_n,
    input  logic             lane_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             cpu_go,
    input  logic             wr_ok,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);
    logic [LANES-1:0] mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // global write overrides; lane enable gates the per-lane selects
        assign mask[g]    = ~wr_all_n | (~lane_en_n & ~lane_sel_n[g]);
        assign lane_we[g] = mask[g] & wr_ok;
    end

    assign wr_req = (|mask) & ~cpu_go;

endmodule

// File: rtl/sbc_store.sv
module sbc_store #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hold,
    input  logic [LANES-1:0]           we,
    input  logic [$clog2(DEPTH)-1:0]   waddr,
    input  logic [LANES*LANE_W-1:0]    wdata,
    input  logic                       rd_en,
    input  logic [$clog2(DEPTH)-1:0]   raddr,
    output logic [LANES*LANE_W-1:0]    rdata_q,
    output logic                       drv_q
);
    localparam int DW = LANES * LANE_W;
    localparam int DB = LANE_W - 1;     // data bits per lane
    localparam int PB = LANES * DB;     // first parity bit

    typedef struct packed {
        logic [DW-1:0] data;
        logic          drv;
    } out_t;

    logic [DW-1:0] mem [DEPTH];
    out_t          o_d, o_q;

    // lane-masked write at the accepting edge
    always_ff @(posedge clk) begin
        if (!hold) begin
            for (int k = 0; k < LANES; k++) begin
                if (we[k]) begin
                    mem[waddr][k*DB +: DB] <= wdata[k*DB +: DB];
                    mem[waddr][PB + k]     <= wdata[PB + k];
                end
            end
        end
    end

    // output register: one edge behind the accepted read
    always_comb begin
        o_d = o_q;
        if (!hold) begin
            o_d.drv = rd_en;
            if (rd_en) begin
                o_d.data = mem[raddr];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rdata_q = o_q.data;
    assign drv_q   = o_q.drv;

endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int SEQ_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_n,
    input  logic                        sel_hi,
    input  logic                        sel_lo_n,
    input  logic                        ld_cpu_n,
    input  logic                        ld_ctl_n,
    input  logic                        step_n,
    input  logic                        wr_all_n,
    input  logic                        lane_en_n,
    input  logic [LANES-1:0]            lane_sel_n,
    input  logic                        out_en_n,
    input  logic                        nap_i,
    input  logic [$clog2(DEPTH)-1:0]    addr_i,
    input  logic [SEQ_W-1:0]            seq_lo_i,
    input  logic [LANES*LANE_W-1:0]     wdata_i,
    output logic [LANES*LANE_W-1:0]     rdata_o,
    output logic                        drive_o
);
    import sbc_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic [AW-1:0] addr;   // current access address
        logic          act;    // burst open
        logic          rd;     // read accepted at last edge
        logic          slp;    // nap seen at last edge
    } front_t;

    front_t           fr_d, fr_q;
    cyc_e             cyc;
    logic             cpu_go;
    logic             wr_ok;
    logic             wr_req;
    logic [LANES-1:0] lane_we;
    logic [DW-1:0]    rdata_q;
    logic             drv_q;

    logic [AW-1:0]    cur_addr;
    logic             cur_act;
    logic             cur_rd;
    logic             cur_slp;

    assign cur_addr = fr_q.addr;
    assign cur_act  = fr_q.act;
    assign cur_rd   = fr_q.rd;
    assign cur_slp  = fr_q.slp;

    sbc_cycle_dec u_dec (
        .en_n     (en_n),
        .sel_hi   (sel_hi),
        .sel_lo_n (sel_lo_n),
        .ld_cpu_n (ld_cpu_n),
        .ld_ctl_n (ld_ctl_n),
        .step_n   (step_n),
        .nap      (nap_i),
        .woke     (cur_slp),
        .act_q    (cur_act),
        .cyc      (cyc),
        .cpu_go   (cpu_go),
        .wr_ok    (wr_ok)
    );

    sbc_lane_dec #(.LANES(LANES)) u_lane (
        .wr_all_n   (wr_all_n),
        .lane_en_n  (lane_en_n),
        .lane_sel_n (lane_sel_n),
        .cpu_go     (cpu_go),
        .wr_ok      (wr_ok),
        .lane_we    (lane_we),
        .wr_req     (wr_req)
    );

    // next front-end state
    always_comb begin
        fr_d     = fr_q;
        fr_d.slp = nap_i;
        if (!nap_i) begin
            unique case (cyc)
                CY_DESEL: begin
                    fr_d.act = 1'b0;
                    fr_d.rd  = 1'b0;
                end
                CY_BEGIN: begin
                    fr_d.addr = addr_i;
                    fr_d.act  = 1'b1;
                    fr_d.rd   = ~|lane_we;
                end
                CY_CONT: begin
                    fr_d.addr[SEQ_W-1:0] = seq_lo_i;
                    fr_d.rd              = ~|lane_we;
                end
                CY_SUSP: begin
                    fr_d.rd = ~|lane_we;
                end
                default: begin
                    fr_d.rd = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    sbc_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (nap_i),
        .we      (lane_we),
        .waddr   (fr_d.addr),
        .wdata   (wdata_i),
        .rd_en   (cur_rd),
        .raddr   (cur_addr),
        .rdata_q (rdata_q),
        .drv_q   (drv_q)
    );

    assign rdata_o = rdata_q;
    assign drive_o = drv_q & ~out_en_n & ~nap_i & ~wr_req;

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nap,
    input logic             woke,
    input logic             en_n,
    input logic             sel_hi,
    input logic             sel_lo_n,
    input logic             ld_cpu_n,
    input logic             ld_ctl_n,
    input logic             step_n,
    input logic             act_q,
    input logic             rd_q,
    input logic             drv_q,
    input logic [AW-1:0]    addr_q,
    input logic [LANES-1:0] lane_we
);

    // R1: a load while unselected opens nothing and reads nothing
    a_r1_desel_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && ((!ld_cpu_n && !en_n) || !ld_ctl_n) && !(!en_n && sel_hi && !sel_lo_n))
        |=> (!rd_q && !act_q));

    // R3: a processor-started cycle never writes a lane
    a_r3_cpu_start_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_cpu_n && !en_n) |-> (lane_we == '0));

    // R6: a suspend cycle keeps the access address
    a_r6_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && !woke && ld_ctl_n && (ld_cpu_n || en_n) && step_n && act_q)
        |=> $stable(addr_q));

    // R9: an accepted read reaches the output register one edge later
    a_r9_read_to_output: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && rd_q) |=> drv_q);

    // R11: nap freezes the front-end state
    a_r11_nap_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        nap |=> ($stable(addr_q) && $stable(rd_q) && $stable(act_q)));

    // R11: first edge after nap closes the burst
    a_r11_wake_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!nap && woke) |=> !act_q);

endmodule

bind sram_burst_ctl sbc_checker #(.AW($clog2(DEPTH)), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nap      (nap_i),
    .woke     (cur_slp),
    .en_n     (en_n),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .ld_cpu_n (ld_cpu_n),
    .ld_ctl_n (ld_ctl_n),
    .step_n   (step_n),
    .act_q    (cur_act),
    .rd_q     (cur_rd),
    .drv_q    (drv_q),
    .addr_q   (cur_addr),
    .lane_we  (lane_we)
);

// File: tb/sram_burst_ctl_bench.sv
module sram_burst_ctl_bench;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int DW    = 36;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             en_n, sel_hi, sel_lo_n, ld_cpu_n, ld_ctl_n, step_n;
    logic             wr_all_n, lane_en_n, out_en_n, nap;
    logic [LANES-1:0] lane_sel_n;
    logic [AW-1:0]    addr;
    logic [1:0]       seq_lo;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic             drive;

    sram_burst_ctl u_sram_burst_ctl (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n), .wr_all_n(wr_all_n),
        .lane_en_n(lane_en_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .nap_i(nap),
        .addr_i(addr), .seq_lo_i(seq_lo), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
    );

    // reference state
    logic [DW-1:0] mmem [DEPTH];
    logic [AW-1:0] m_addr;
    logic          m_act, m_rd, m_drv, m_slp;
    logic [DW-1:0] m_data;

    int    nchk = 0;
    int    nerr = 0;
    string tag  = "R13";

    task automatic chk(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [LANES-1:0] lane_mask();
        if (!wr_all_n)       return '1;
        else if (!lane_en_n) return ~lane_sel_n;
        else                 return '0;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [LANES-1:0] m);
        logic [DW-1:0] r = old;
        for (int k = 0; k < LANES; k++) begin
            if (m[k]) begin
                r[8*k +: 8] = nw[8*k +: 8];
                r[32 + k]   = nw[32 + k];
            end
        end
        return r;
    endfunction

    function automatic logic exp_drive();
        logic cpu = !ld_cpu_n && !en_n;
        return m_drv && !out_en_n && !nap && !((lane_mask() != 0) && !cpu);
    endfunction

    task automatic model_reset();
        m_addr = '0; m_act = 1'b0; m_rd = 1'b0; m_drv = 1'b0; m_slp = 1'b0; m_data = '0;
    endtask

    task automatic model_edge();
        logic             wake, n_drv, sel, cpu, load;
        logic [DW-1:0]    n_data;
        logic [LANES-1:0] m;
        if (nap) begin
            m_slp = 1'b1;
            return;
        end
        wake   = m_slp;
        m_slp  = 1'b0;
        n_drv  = m_rd;
        n_data = m_rd ? mmem[m_addr] : m_data;
        sel    = !en_n && sel_hi && !sel_lo_n;
        cpu    = !ld_cpu_n && !en_n;
        load   = cpu || !ld_ctl_n;
        m      = lane_mask();
        if (wake) begin
            m_act = 1'b0; m_rd = 1'b0;
        end else if (load) begin
            if (!sel) begin
                m_act = 1'b0; m_rd = 1'b0;
            end else begin
                m_addr = addr; m_act = 1'b1;
                if (cpu) m_rd = 1'b1;
                else begin
                    mmem[m_addr] = merge(mmem[m_addr], wdata, m);
                    m_rd = (m == 0);
                end
            end
        end else if (m_act) begin
            if (!step_n) m_addr = {m_addr[AW-1:2], seq_lo};
            mmem[m_addr] = merge(mmem[m_addr], wdata, m);
            m_rd = (m == 0);
        end else begin
            m_rd = 1'b0;
        end
        m_drv  = n_drv;
        m_data = n_data;
    endtask

    task automatic set_def();
        en_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0; ld_cpu_n = 1'b1; ld_ctl_n = 1'b1;
        step_n = 1'b1; wr_all_n = 1'b1; lane_en_n = 1'b1; lane_sel_n = '1; out_en_n = 1'b0;
        nap = 1'b0; seq_lo = '0; addr = '0; wdata = '0;
    endtask

    // inputs are already set at a falling edge
    task automatic tick();
        #1;
        chk("drive", {35'd0, drive}, {35'd0, exp_drive()});
        if (m_drv) chk("data", rdata, m_data);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        set_def();
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        tag = "R13";
        chk("reset drive", {35'd0, drive}, 36'd0);
        rst_n = 1'b1;
        tick();
        chk("post-reset drive", {35'd0, drive}, 36'd0);

        // R4: fill array through controller-strobe global writes
        tag = "R4";
        for (int a = 0; a < DEPTH; a++) begin
            set_def(); ld_ctl_n = 1'b0; wr_all_n = 1'b0; addr = AW'(a);
            wdata = {4'(a), 8'(a), 8'(~a), 8'(a + 8'h40), 8'(a ^ 8'h5A)};
            tick();
        end

        // R12 then R9: write, read next cycle, watch latency
        tag = "R12";
        set_def(); ld_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 6'd10; wdata = 36'hC_DEAD_BEEF; tick();
        set_def(); ld_cpu_n = 1'b0; addr = 6'd10; tick();
        tag = "R9";
        set_def(); tick(); tick();

        // R3: processor start ignores write controls
        tag = "R3";
        set_def(); ld_cpu_n = 1'b0; addr = 6'd7; wr_all_n = 1'b0; wdata = 36'h0_1111_2222; tick();
        set_def(); tick(); tick();

        // R2: processor strobe with enable high is not a load
        tag = "R2";
        set_def(); en_n = 1'b1; ld_cpu_n = 1'b0; addr = 6'd50; tick(); tick();
        set_def(); tick();

        // R5: linear continuation supplied by sequencer
        tag = "R5";
        set_def(); ld_ctl_n = 1'b0; addr = 6'd20; tick();
        for (int s = 1; s <= 4; s++) begin
            set_def(); step_n = 1'b0; seq_lo = 2'(s); tick();
        end

        // R6: suspend repeats current address
        tag = "R6";
        set_def(); tick(); tick();

        // R7: lane enable high blocks selects; global write overrides selects
        tag = "R7";
        set_def(); ld_ctl_n = 1'b0; addr = 6'd30; lane_sel_n = '0; wdata = 36'hF_FFFF_FFFF; tick();
        set_def(); wr_all_n = 1'b0; lane_en_n = 1'b0; lane_sel_n = '1; wdata = 36'h5_0123_4567; tick();
        set_def(); ld_cpu_n = 1'b0; addr = 6'd30; tick();
        set_def(); tick(); tick();

        // R8: two non-adjacent lanes written
        tag = "R8";
        set_def(); ld_ctl_n = 1'b0; addr = 6'd31; lane_en_n = 1'b0; lane_sel_n = 4'b1010;
        wdata = 36'hF_AABB_CCDD; tick();
        set_def(); ld_cpu_n = 1'b0; addr = 6'd31; tick();
        set_def(); tick(); tick();

        // R10: output enable high, then write request blanks drive
        tag = "R10";
        set_def(); out_en_n = 1'b1; tick();
        set_def(); lane_en_n = 1'b0; lane_sel_n = 4'b1110; wdata = 36'h0_0000_0077; tick();
        set_def(); ld_cpu_n = 1'b0; addr = 6'd31; wr_all_n = 1'b0; tick();
        set_def(); tick(); tick();

        // R11: nap freezes everything, wake cycle is a deselect
        tag = "R11";
        for (int n = 0; n < 4; n++) begin
            set_def(); nap = 1'b1; ld_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 6'd12;
            wdata = {4'($urandom), 32'($urandom)}; tick();
        end
        set_def(); ld_cpu_n = 1'b0; addr = 6'd12; tick();
        set_def(); wr_all_n = 1'b0; wdata = 36'h9_9999_9999; tick();
        set_def(); ld_cpu_n = 1'b0; addr = 6'd12; tick();
        set_def(); tick(); tick();

        // R1: unselected load: no write, burst closed
        tag = "R1";
        set_def(); sel_hi = 1'b0; ld_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 6'd40; wdata = 36'h3_3333_3333; tick();
        set_def(); step_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h4_4444_4444; tick();
        set_def(); ld_cpu_n = 1'b0; addr = 6'd40; tick();
        set_def(); tick(); tick();

        // random mix, judged by the model (R9 output timing throughout)
        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            en_n       = ($urandom % 8) == 0;
            sel_hi     = ($urandom % 8) != 0;
            sel_lo_n   = ($urandom % 8) == 0;
            ld_cpu_n   = ($urandom % 4) != 0;
            ld_ctl_n   = ($urandom % 4) != 0;
            step_n     = 1'($urandom);
            wr_all_n   = ($urandom % 4) != 0;
            lane_en_n  = 1'($urandom);
            lane_sel_n = 4'($urandom);
            out_en_n   = ($urandom % 8) == 0;
            nap        = ($urandom % 32) == 0;
            seq_lo     = 2'($urandom);
            addr       = 6'($urandom);
            wdata      = {4'($urandom), 32'($urandom)};
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule